// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between an execute stage and a 32-bit, word-wide, little-endian data memory. For each access it forms the effective address as a base value plus a sign-extended 16-bit offset. It sends memory the word address with the two low bits cleared. Memory always moves whole words, and the unit works out which bytes of that word the access concerns.

On a load, the unit takes the addressed byte, halfword or word out of the fetched word. It extends the value to 32 bits, with sign or zero fill, and stores it in a result register. On a store, it moves the low byte or halfword of the source register onto the addressed lanes and raises only the matching per-byte write enables, so every other byte of the memory word is left as it was.

Halfwords must start at an even address and words at a multiple of four. An access that breaks this rule raises an alignment error. It writes nothing and does not change the load result.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `baseAddr` plus `offset` sign-extended to 32 bits. `memAddr` is that address with bits 1:0 forced to zero.
- R2: `accSize` chooses the width: 00 is a byte, 01 a halfword, 10 a word. The code 11 acts exactly like 10.
- R3: Byte lanes are little-endian. Lane k is `memRdata[8k+7:8k]`, and effective-address bits 1:0 name the lowest lane the access touches.
- R4: When `accUnsigned` is 0, byte and halfword loads are sign-extended. When it is 1, they are zero-extended. Word loads return the fetched word unchanged.
- R5: `loadData` resets to 0. It takes the extracted value at the rising edge that ends a valid, aligned load, and holds its value in every other cycle.
- R6: On an aligned store, `memByteEn` (bit k is lane k) is 0001 shifted left by address bits 1:0 for a byte, 0011 shifted left by them for a halfword, and 1111 for a word. `memWdata` carries the source byte or halfword on those lanes.
- R7: Applying the enabled lanes of `memWdata` to the old memory word changes exactly the bytes the store names. `memByteEn` is 0000 for loads and whenever `accValid` is low.
- R8: A halfword at an odd address, or a word whose address bits 1:0 are nonzero, raises `alignErr`. Such an access forces `memByteEn` to 0000 and leaves `loadData` unchanged. Byte accesses never raise the error.
- R9: Take the fetched word 0x5A137CF8. A signed byte load at byte offset 2 returns 0x00000013, and a signed halfword load at offset 0 returns 0x00007CF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accStore | input | 1 | 1 = store, 0 = load |
| accSize | input | 2 | Access width code |
| accUnsigned | input | 1 | Zero-extend narrow loads |
| baseAddr | input | 32 | Base register value |
| offset | input | 16 | Signed address offset |
| storeData | input | 32 | Source register for stores |
| memRdata | input | 32 | Word fetched from memory |
| memAddr | output | 32 | Word-aligned memory address |
| memByteEn | output | 4 | Per-lane write enables |
| memWdata | output | 32 | Lane-placed store data |
| alignErr | output | 1 | Misaligned access |
| loadData | output | 32 | Registered, extended load result |

## Verification
Address, lane and enable logic is combinational, so a fault in it shows at the ports in the same cycle as the access. A wrong lane shift, for example, corrupts the merged memory word at once. A wrong sign or zero fill, a missed capture, or a capture on a misaligned access shows on `loadData` one edge later. Because a bad capture would leave stale data behind, every access is followed by a read of the result register. The sweep runs every width code, extension mode, store/load direction and low address pair over several data patterns.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } accSize_e;

  typedef struct packed {
    logic capture;
    logic signExt;
    logic isByte;
    logic isHalf;
  } laneStrobes_t;
endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accStore,
  input  logic [1:0]       accSize,
  input  logic             accUnsigned,
  input  logic [OFS_W-1:0] addrLow,
  output laneStrobes_t     strobes,
  output logic [LANES-1:0] byteEn,
  output logic             alignErr
);
  logic isByte, isHalf, isWord, misaligned;
  logic [LANES-1:0] baseMask, shiftedMask;

  always_comb begin
    isByte = (accSize == SZ_BYTE);
    isHalf = (accSize == SZ_HALF);
    isWord = accSize[1];
    if (isHalf)      misaligned = addrLow[0];
    else if (isWord) misaligned = (addrLow != '0);
    else             misaligned = 1'b0;
    alignErr = accValid & misaligned;
    baseMask = isByte ? LANES'(1) : LANES'(3);
    shiftedMask = isWord ? {LANES{1'b1}} : (baseMask << addrLow);
    byteEn = (accValid & accStore & ~misaligned) ? shiftedMask : '0;
    strobes.capture = accValid & ~accStore & ~misaligned;
    strobes.signExt = ~accUnsigned;
    strobes.isByte  = isByte;
    strobes.isHalf  = isHalf;
  end

  AST_ERR_NO_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (byteEn == '0)); // R8
  AST_ERR_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> !strobes.capture); // R8
  AST_ENABLES_ONLY_STORE: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && accStore) |-> (byteEn == '0)); // R7
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accStore && accSize == SZ_BYTE) |-> ($countones(byteEn) == 1)); // R6
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accStore && accSize == SZ_HALF && !alignErr) |-> ($countones(byteEn) == 2)); // R6
endmodule

// File: rtl/lsu_lane_datapath.sv
module lsu_lane_datapath
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobes_t      strobes,
  input  logic [DATA_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [OFS_W-1:0]  addrLow,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData
);
  logic [DATA_W-1:0] effAddr, laneShifted, extended;
  logic [7:0]  byteVal;
  logic [15:0] halfVal;

  assign effAddr = baseAddr + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign addrLow = effAddr[OFS_W-1:0];
  assign memAddr = {effAddr[DATA_W-1:OFS_W], {OFS_W{1'b0}}};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_storeLane
    always_comb begin
      if (strobes.isByte)      memWdata[lane*8 +: 8] = storeData[7:0];
      else if (strobes.isHalf) memWdata[lane*8 +: 8] = storeData[(lane%2)*8 +: 8];
      else                     memWdata[lane*8 +: 8] = storeData[lane*8 +: 8];
    end
  end

  always_comb begin
    laneShifted = memRdata >> {addrLow, 3'b000};
    byteVal = laneShifted[7:0];
    halfVal = laneShifted[15:0];
    if (strobes.isByte)
      extended = {{(DATA_W-8){strobes.signExt & byteVal[7]}}, byteVal};
    else if (strobes.isHalf)
      extended = {{(DATA_W-16){strobes.signExt & halfVal[15]}}, halfVal};
    else
      extended = memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                loadData <= '0;
    else if (strobes.capture) loadData <= extended;
  end

  AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(loadData)); // R5
  AST_WORD_LOAD_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.isByte && !strobes.isHalf) |=> (loadData == $past(memRdata))); // R4
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accStore,
  input  logic [1:0]        accSize,
  input  logic              accUnsigned,
  input  logic [DATA_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic              alignErr,
  output logic [DATA_W-1:0] loadData
);
  laneStrobes_t strobes;
  logic [OFS_W-1:0] addrLow;

  lsu_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accStore(accStore),
    .accSize(accSize), .accUnsigned(accUnsigned), .addrLow(addrLow),
    .strobes(strobes), .byteEn(memByteEn), .alignErr(alignErr)
  );

  lsu_lane_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .baseAddr(baseAddr),
    .offset(offset), .storeData(storeData), .memRdata(memRdata),
    .addrLow(addrLow), .memAddr(memAddr), .memWdata(memWdata),
    .loadData(loadData)
  );

  AST_ERR_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> $stable(loadData)); // R8
  AST_NO_ERR_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b00) |-> !alignErr); // R8
endmodule

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accStore = 1'b0, accUnsigned = 1'b0;
  logic [1:0]  accSize = 2'b00;
  logic [31:0] baseAddr = '0, storeData = '0, memRdata = '0;
  logic [15:0] offset = '0;
  logic [31:0] memAddr, memWdata, loadData;
  logic [3:0]  memByteEn;
  logic        alignErr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [31:0] expLoad = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_align u_lsu_lane_align (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accStore(accStore),
    .accSize(accSize), .accUnsigned(accUnsigned), .baseAddr(baseAddr),
    .offset(offset), .storeData(storeData), .memRdata(memRdata),
    .memAddr(memAddr), .memByteEn(memByteEn), .memWdata(memWdata),
    .alignErr(alignErr), .loadData(loadData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runAccess(input logic st, input logic [1:0] sz, input logic uns,
                           input logic [31:0] base, input logic [15:0] off,
                           input logic [31:0] sdata, input logic [31:0] rdata);
    logic [31:0] ea, mask, merged, expMerged, v;
    logic [1:0] lo;
    logic mis;
    int nb;
    logic [3:0] expEn;
    string tagSz;
    @(negedge clk);
    accValid = 1'b1; accStore = st; accSize = sz; accUnsigned = uns;
    baseAddr = base; offset = off; storeData = sdata; memRdata = rdata;
    #1;
    ea = base + {{16{off[15]}}, off};
    lo = ea[1:0];
    nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    mis = (nb == 2 && lo[0]) || (nb == 4 && lo != 2'b00);
    tagSz = (sz == 2'b11) ? "R2" : "R6";
    check("R1 memAddr", memAddr, ea & 32'hFFFF_FFFC);
    check("R8 alignErr", {31'b0, alignErr}, {31'b0, mis});
    if (nb == 4) expEn = 4'hF;
    else expEn = 4'((nb == 1 ? 1 : 3) << lo);
    if (!st || mis) expEn = 4'h0;
    check({tagSz, " byteEn"}, {28'b0, memByteEn}, {28'b0, expEn});
    if (st && !mis) begin
      mask = (nb == 4) ? 32'hFFFF_FFFF : (((32'h1 << (8*nb)) - 1) << (8*lo));
      expMerged = (rdata & ~mask) | ((sdata << (8*lo)) & mask);
      for (int k = 0; k < 4; k++)
        merged[k*8 +: 8] = memByteEn[k] ? memWdata[k*8 +: 8] : rdata[k*8 +: 8];
      check("R7 merged memory word", merged, expMerged);
    end
    if (!st && !mis) begin
      v = rdata >> (8*lo);
      if (nb == 1)      expLoad = uns ? (v & 32'hFF)   : {{24{v[7]}}, v[7:0]};
      else if (nb == 2) expLoad = uns ? (v & 32'hFFFF) : {{16{v[15]}}, v[15:0]};
      else              expLoad = rdata;
    end
    @(posedge clk); #1;
    if (mis)           check("R8 loadData held", loadData, expLoad);
    else if (st)       check("R5 loadData held on store", loadData, expLoad);
    else if (nb == 4)  check("R4 word load", loadData, expLoad);
    else if (uns)      check("R4 zero extend", loadData, expLoad);
    else               check("R3 lane select/sign extend", loadData, expLoad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    logic [15:0] offs [3];
    pats[0] = 32'h5A13_7CF8; pats[1] = 32'h80FF_017F; pats[2] = 32'hA5C3_8E11;
    offs[0] = 16'h0000; offs[1] = 16'hFFFC; offs[2] = 16'h0008;
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset loadData", loadData, 32'h0);
    check("R7 idle byteEn", {28'b0, memByteEn}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    accValid = 1'b0; accStore = 1'b1; accSize = 2'b10;
    #1;
    check("R7 invalid store byteEn", {28'b0, memByteEn}, 32'h0);
    @(posedge clk); #1;
    check("R5 idle hold", loadData, 32'h0);

    runAccess(1'b0, 2'b00, 1'b0, 32'h0000_0002, 16'h0000, '0, 32'h5A13_7CF8);
    check("R9 byte example", loadData, 32'h0000_0013);
    runAccess(1'b0, 2'b01, 1'b0, 32'h0000_0000, 16'h0000, '0, 32'h5A13_7CF8);
    check("R9 half example", loadData, 32'h0000_7CF8);

    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 3; o++)
        for (int sz = 0; sz < 4; sz++)
          for (int u = 0; u < 2; u++)
            for (int st = 0; st < 2; st++)
              for (int lo = 0; lo < 4; lo++)
                runAccess(st[0], sz[1:0], u[0], 32'h1000_0010 + 32'(lo),
                          offs[o], 32'h1234_56C9 ^ pats[(p+1)%3], pats[p]);

    @(negedge clk); accValid = 1'b0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule